// File: doc/BRIEF.md
# Identification Page Lock Controller

This block is the serial front end of a memory device that has a one-time-lockable identification page. It behaves as an SPI mode-0 slave. Three instructions are decoded: Write Enable, Read Lock Status and Lock ID. The block holds the Write Enable Latch, a busy timer for the self-timed write cycle, and a sticky lock flag. The flag stands in for the non-volatile lock state, so only a power-on reset clears it.

All SPI pins are oversampled by the system clock through a synchronizer. SCK rising edges shift SI in MSB first, and SCK falling edges update SO. A Lock ID frame is judged at the moment chip select returns high. To execute, the frame must have delivered exactly one opcode byte, two address bytes and one data byte, and every gating condition must hold. An accepted frame holds `busy_o` high for `TWR_CLKS` system clocks, and the lock is set when that window closes. Read Lock Status drives a status byte whose least significant bit is the lock flag, and repeats that byte for as long as chip select stays low.

Top module: `idlock_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0, `so_oe_o` is 0 and the lock flag is clear (a status read returns 0x00).
- R2: A Read Lock Status frame consists of opcode 0x83, two address bytes with address bit 10 set, then continued clocking. On the SCK falling edge after the 24th bit, SO starts returning the status byte MSB first, with bits 7..1 zero and bit 0 equal to the lock flag. SO changes only after an SCK falling edge, and `so_oe_o` is high during this read phase.
- R3: While chip select stays low after the first status byte, the identical byte is shifted out again.
- R4: A Read Lock Status frame whose address bit 10 is 0 leaves `so_oe_o` low for the whole frame. SO is never enabled while chip select is high.
- R5: A Lock ID frame is accepted when all of the following hold: opcode 0x82, address bit 10 set (other address bits ignored), data bit 1 set (other data bits ignored), Write Enable Latch set, and none of the rejections in R6 to R11 applies. After chip select rises on an accepted frame, `busy_o` stays high for exactly `TWR_CLKS` clocks. The lock flag becomes 1 in the same cycle that `busy_o` falls.
- R6: Lock ID is rejected when no Write Enable (opcode 0x06, exactly 8 bits) has been accepted beforehand.
- R7: Lock ID is rejected while `bp_i` equals 2'b11.
- R8: Lock ID is rejected when address bit 10 is 0 or data bit 1 is 0.
- R9: Lock ID is rejected when chip select rises after 31 or after 33 bits instead of exactly 32.
- R10: While a write cycle is running, Write Enable and Lock ID are ignored, and the busy window is not extended.
- R11: Once the lock flag is set, Lock ID is rejected and `busy_o` stays low.
- R12: The lock flag never clears except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bp_i | input | 2 | Block-protect bits; 2'b11 forbids locking |
| sck_i | input | 1 | SPI serial clock (mode 0) |
| cs_n_i | input | 1 | SPI chip select, active low |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for SO; low means tri-stated |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The hardest state to reach is a Lock ID that arrives while a write cycle is already running. Only an accepted Lock ID starts a write cycle, and that same cycle then sets the lock, which hides any later attempt behind the already-locked rejection. The stimulus therefore sends a second Write Enable and a second valid Lock ID frame immediately after `busy_o` rises, while the timer is still counting. It then measures the total number of busy clocks against `TWR_CLKS` to show that the window was neither restarted nor extended. Byte-boundary rejection is reached by cutting the frame one bit short and by adding one extra bit.

// File: rtl/idlock_pkg.sv
package idlock_pkg;

    localparam int OP_W         = 8;
    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 8;
    localparam int STAT_W       = 8;
    localparam int KEY_ADDR_BIT = 10;
    localparam int KEY_DATA_BIT = 1;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
        logic cs_active;
        logic sdi;
    } spi_evt_t;

    function automatic logic protect_full(input logic [1:0] bp);
        return &bp;
    endfunction

    function automatic logic [STAT_W-1:0] mk_status(input logic locked);
        logic [STAT_W-1:0] s;
        s    = '0;
        s[0] = locked;
        return s;
    endfunction

endpackage

// File: rtl/idlock_spi_sync.sv
module idlock_spi_sync
    import idlock_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_i,
    input  logic     cs_n_i,
    input  logic     si_i,
    output spi_evt_t evt_o
);

    localparam logic [2:0] IDLE_PINS = 3'b010;

    logic [2:0] stg_q [SYNC_STAGES];
    logic       sck_prev_q;
    logic       csn_prev_q;
    logic [2:0] cur;

    always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= IDLE_PINS;
        else     stg_q[0] <= {sck_i, cs_n_i, si_i};
    end

    for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[k] <= IDLE_PINS;
            else     stg_q[k] <= stg_q[k-1];
        end
    end

    assign cur = stg_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q <= 1'b0;
            csn_prev_q <= 1'b1;
        end else begin
            sck_prev_q <= cur[2];
            csn_prev_q <= cur[1];
        end
    end

    always_comb begin
        evt_o.sck_rise  =  cur[2] && !sck_prev_q && !cur[1];
        evt_o.sck_fall  = !cur[2] &&  sck_prev_q && !cur[1];
        evt_o.cs_rise   =  cur[1] && !csn_prev_q;
        evt_o.cs_active = !cur[1];
        evt_o.sdi       =  cur[0];
    end

endmodule

// File: rtl/idlock_shifter.sv
module idlock_shifter
    import idlock_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  spi_evt_t           evt_i,
    output logic [CNT_W-1:0]   bit_cnt_o,
    output logic [FRAME_W-1:0] shreg_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (!evt_i.cs_active) begin
            cnt_q <= '0;
        end else if (evt_i.sck_rise) begin
            sh_q  <= {sh_q[FRAME_W-2:0], evt_i.sdi};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_cnt_o = cnt_q;
    assign shreg_o   = sh_q;

endmodule

// File: rtl/idlock_wr_timer.sv
module idlock_wr_timer #(
    parameter int TWR_CLKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = (TWR_CLKS > 1) ? $clog2(TWR_CLKS) : 1;
    localparam logic [CW-1:0] LOAD = CW'(TWR_CLKS - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign done_o = busy_q && (cnt_q == '0);
    assign busy_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end
    end

endmodule

// File: rtl/idlock_ctrl.sv
module idlock_ctrl
    import idlock_pkg::*;
#(
    parameter int         TWR_CLKS    = 1000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] OP_WREN     = 8'h06,
    parameter logic [7:0] OP_RDLS     = 8'h83,
    parameter logic [7:0] OP_LOCK     = 8'h82
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bp_i,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       si_i,
    output logic       so_o,
    output logic       so_oe_o,
    output logic       busy_o
);

    localparam int FRAME_W  = OP_W + ADDR_W + DATA_W;
    localparam int RD_START = OP_W + ADDR_W;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int OBIT_W   = $clog2(STAT_W);
    localparam logic [CNT_W-1:0] CNT_OP    = CNT_W'(OP_W);
    localparam logic [CNT_W-1:0] CNT_RD    = CNT_W'(RD_START);
    localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_W);
    localparam logic [OBIT_W-1:0] OBIT_TOP = OBIT_W'(STAT_W - 1);

    spi_evt_t           evt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               unused_bits;

    logic cs_rise_s, sck_fall_s, cs_active_s;
    logic wel_q, lock_q;
    logic wren_hit, lock_hit, rd_hit;
    logic busy, wr_done;
    logic rd_mode_q, oe_q, so_q;
    logic [OBIT_W-1:0] obit_q;
    logic [STAT_W-1:0] status;

    idlock_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .sck_i  (sck_i),
        .cs_n_i (cs_n_i),
        .si_i   (si_i),
        .evt_o  (evt)
    );

    idlock_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .bit_cnt_o (bit_cnt),
        .shreg_o   (shreg)
    );

    assign cs_rise_s   = evt.cs_rise;
    assign sck_fall_s  = evt.sck_fall;
    assign cs_active_s = evt.cs_active;
    assign unused_bits = ^shreg;

    // Frame decode at chip-select release.
    always_comb begin
        wren_hit = cs_rise_s && (bit_cnt == CNT_OP)
                && (shreg[OP_W-1:0] == OP_WREN) && !busy;
        lock_hit = cs_rise_s && (bit_cnt == CNT_FRAME)
                && (shreg[FRAME_W-1 -: OP_W] == OP_LOCK)
                && shreg[DATA_W + KEY_ADDR_BIT]
                && shreg[KEY_DATA_BIT]
                && wel_q && !protect_full(bp_i) && !busy && !lock_q;
        rd_hit   = (bit_cnt == CNT_RD)
                && (shreg[RD_START-1 -: OP_W] == OP_RDLS)
                && shreg[KEY_ADDR_BIT];
    end

    idlock_wr_timer #(.TWR_CLKS(TWR_CLKS)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (lock_hit),
        .busy_o  (busy),
        .done_o  (wr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (wr_done)       wel_q <= 1'b0;
            else if (wren_hit) wel_q <= 1'b1;
            if (wr_done)       lock_q <= 1'b1;
        end
    end

    assign status = mk_status(lock_q);

    // Status read engine: SO moves on SCK falling edges, byte repeats.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_mode_q <= 1'b0;
            oe_q      <= 1'b0;
            so_q      <= 1'b0;
            obit_q    <= OBIT_TOP;
        end else if (!cs_active_s) begin
            rd_mode_q <= 1'b0;
            oe_q      <= 1'b0;
            obit_q    <= OBIT_TOP;
        end else if (sck_fall_s) begin
            if (rd_mode_q) begin
                so_q   <= status[obit_q];
                obit_q <= obit_q - 1'b1;
            end else if (rd_hit) begin
                rd_mode_q <= 1'b1;
                oe_q      <= 1'b1;
                so_q      <= status[OBIT_TOP];
                obit_q    <= OBIT_TOP - 1'b1;
            end
        end
    end

    assign so_o    = so_q;
    assign so_oe_o = oe_q;
    assign busy_o  = busy;

endmodule

// File: rtl/idlock_chk.sv
module idlock_chk (
    input logic clk,
    input logic rst,
    input logic busy_o,
    input logic so_o,
    input logic so_oe_o,
    input logic lock_q,
    input logic cs_rise_s,
    input logic sck_fall_s,
    input logic cs_active_s
);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(cs_rise_s));

    // R5
    lock_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $fell(busy_o));

    // R11
    locked_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !$rose(busy_o));

    // R12
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R4
    oe_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_active_s && $past(!cs_active_s)) |-> !so_oe_o);

    // R2
    so_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(so_o) |-> $past(sck_fall_s));

endmodule

bind idlock_ctrl idlock_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o),
    .lock_q      (lock_q),
    .cs_rise_s   (cs_rise_s),
    .sck_fall_s  (sck_fall_s),
    .cs_active_s (cs_active_s)
);

// File: tb/idlock_ctrl_tb_top.sv
module idlock_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int TWR        = 1000;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic        wren;
        logic [1:0]  bp;
        logic [7:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [5:0]  nbits;
        logic        exp_busy;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'b00, 8'h82, 16'h0400, 8'h02, 6'd32, 1'b0, 4'd6},  // R6 no WREN
        '{1'b1, 2'b11, 8'h82, 16'h0400, 8'h02, 6'd32, 1'b0, 4'd7},  // R7 full protect
        '{1'b1, 2'b00, 8'h82, 16'hFBFF, 8'h02, 6'd32, 1'b0, 4'd8},  // R8 address bit 10 clear
        '{1'b1, 2'b01, 8'h82, 16'h0400, 8'hFD, 6'd32, 1'b0, 4'd8},  // R8 data bit 1 clear
        '{1'b1, 2'b00, 8'h82, 16'h0400, 8'h02, 6'd31, 1'b0, 4'd9},  // R9 short frame
        '{1'b1, 2'b00, 8'h82, 16'h0400, 8'h02, 6'd33, 1'b0, 4'd9},  // R9 long frame
        '{1'b1, 2'b10, 8'h82, 16'hFFFF, 8'h02, 6'd32, 1'b1, 4'd5},  // R5 accepted
        '{1'b1, 2'b00, 8'h82, 16'h0400, 8'h02, 6'd32, 1'b0, 4'd11}  // R11 already locked
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bp  = 2'b00;
    logic       sck = 1'b0;
    logic       csn = 1'b1;
    logic       si  = 1'b0;
    logic       so, so_oe, busy;
    logic       bclr = 1'b1;
    int         bcnt;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (bclr)      bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
    end

    idlock_ctrl #(.TWR_CLKS(TWR)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .bp_i    (bp),
        .sck_i   (sck),
        .cs_n_i  (csn),
        .si_i    (si),
        .so_o    (so),
        .so_oe_o (so_oe),
        .busy_o  (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] tx, input int nbits, input int nrd,
                         output logic [15:0] rx, output bit oe_any, output bit oe_all);
        rx = '0; oe_any = 1'b0; oe_all = 1'b1;
        @(negedge clk);
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits + nrd; i++) begin
            si = (i < 32 && i < nbits) ? tx[31 - i] : 1'b0;
            wait_clk(HALF);
            if (so_oe) oe_any = 1'b1;
            if (i >= 24 && i - 24 < nrd) begin
                rx = {rx[14:0], so};
                if (!so_oe) oe_all = 1'b0;
            end
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(10);
    endtask

    task automatic wren();
        logic [15:0] rx; bit a, b;
        frame({8'h06, 24'h0}, 8, 0, rx, a, b);
    endtask

    task automatic rd_status(input logic [15:0] addr, output logic [15:0] rx,
                             output bit oe_any, output bit oe_all);
        frame({8'h83, addr, 8'h00}, 24, 16, rx, oe_any, oe_all);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rx; bit oa, ol;
        wait_clk(5);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
        chk(so_oe == 1'b0, "R1 oe after reset", 32'(so_oe), 0);
        rst = 1'b0;
        bclr = 1'b0;
        wait_clk(3);

        // R2 R3 status while unlocked
        rd_status(16'h0400, rx, oa, ol);
        chk(rx[15:8] == 8'h00, "R2 unlocked status byte", 32'(rx[15:8]), 0);
        chk(rx[7:0] == 8'h00, "R3 repeated unlocked byte", 32'(rx[7:0]), 0);
        chk(ol == 1'b1, "R2 oe during read phase", 32'(ol), 1);

        // R4 address bit 10 clear: no output enable
        rd_status(16'hFBFF, rx, oa, ol);
        chk(oa == 1'b0, "R4 oe with bad address", 32'(oa), 0);

        // Table walk over Lock ID attempts
        for (int v = 0; v < NVEC; v++) begin
            bp = VECS[v].bp;
            if (VECS[v].wren) wren();
            @(negedge clk); bclr = 1'b1;
            @(negedge clk); bclr = 1'b0;
            frame({VECS[v].op, VECS[v].addr, VECS[v].data}, int'(VECS[v].nbits), 0, rx, oa, ol);
            chk(busy == VECS[v].exp_busy, $sformatf("R%0d vector %0d busy", VECS[v].req, v),
                32'(busy), 32'(VECS[v].exp_busy));
            if (VECS[v].exp_busy) begin
                // R10 Write Enable and Lock ID during the write cycle
                wren();
                frame({8'h82, 16'h0400, 8'h02}, 32, 0, rx, oa, ol);
                while (busy) @(negedge clk);
                wait_clk(3);
                chk(bcnt == TWR, "R10 R5 busy width", 32'(bcnt), 32'(TWR));
            end
        end
        bp = 2'b00;

        // R2 R3 status once locked
        rd_status(16'h0400, rx, oa, ol);
        chk(rx[15:8] == 8'h01, "R2 locked status byte", 32'(rx[15:8]), 32'h01);
        chk(rx[7:0] == 8'h01, "R3 repeated locked byte", 32'(rx[7:0]), 32'h01);

        // R12 lock survives many deselects; only reset clears
        wren();
        rd_status(16'h0400, rx, oa, ol);
        chk(rx[15:8] == 8'h01, "R12 lock sticky", 32'(rx[15:8]), 32'h01);
        @(negedge clk); rst = 1'b1;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(3);
        rd_status(16'h0400, rx, oa, ol);
        chk(rx[15:8] == 8'h00, "R1 lock cleared by reset", 32'(rx[15:8]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule